// File: doc/BRIEF.md
# DMA Request Router Channel with Synchronized Batching

This block is one output channel of a DMA request router. A selector picks one of several peripheral request lines and hands it on to a single DMA controller channel. In its plain mode the chosen line passes straight through. In its synchronized mode, forwarding is shut until a chosen edge appears on a selectable trigger input. After that edge a programmed number of requests gets through, and then the gate closes again.

The channel can also count batches of forwarded requests and emit a one-cycle event pulse when each batch ends. A trigger edge that arrives while a batch is still open is an overrun. It sets a sticky flag that software clears by writing a one, and that flag can raise an interrupt. All settings sit in one 32-bit control word behind a small register port. Address 0 holds the control word and address 1 holds the status word.

Top module: `dma_req_router`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, and `req_out`, `evt_out` and `irq` are low.
- R2: Request select (control bits 7:0) code k in 1..17 routes `req_in[k-1]`. Code 0 and codes 18..255 route nothing, so `req_out` stays low.
- R3: With sync enable (bit 16) at 0, a rising request on the routed line is forwarded in the same cycle, and it stays forwarded until the line falls.
- R4: With sync enable at 1, the gate opens in the cycle after a qualifying trigger edge. The gate then forwards count+1 rising requests, where count is control bits 23:19, and after that blocks new requests until the next trigger edge. A request already being forwarded is held until it falls.
- R5: Edge mode (bits 18:17) selects what counts as a trigger edge: 0 is none (the gate never opens), 1 is rising, 2 is falling, 3 is both. Edges are found by comparing the routed trigger input with its registered copy.
- R6: With event enable (bit 9) at 1, `evt_out` is high for exactly the one cycle after the rising request that completes a batch of count+1. This holds with or without sync enable.
- R7: A control write changes the count field only if sync enable and event enable were both 0 before the write. Otherwise the count keeps its old value while the other fields update.
- R8: A qualifying trigger edge with sync enable at 1, while a batch is open and not completing in that cycle, sets the sticky overrun flag (status bit 0) and leaves the batch running. `irq` equals the flag ANDed with overrun interrupt enable (bit 8).
- R9: A write to address 1 with data bit 0 at 1 clears the overrun flag, unless a new overrun is set in the same cycle.
- R10: A control write that changes the request select or the trigger select restarts the batch count from zero.
- R11: Trigger select (bits 28:24) codes 0..15 route `sync_in[code]`. Codes 16..31 route nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 17 | Peripheral request lines |
| sync_in | input | 16 | Trigger inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 32 | Read data (combinational) |
| req_out | output | 1 | Request to the DMA controller channel |
| evt_out | output | 1 | Batch-complete event pulse |
| irq | output | 1 | Overrun interrupt |

## Verification
The bench targets the last request of a batch. A design with an off-by-one count would pass one request too many or one too few, and it would move the event pulse by a full request. The bench checks that writes to the count are refused while the channel is active. A design without the lock would show the new count on readback. It also drives a trigger edge into an open batch, where a design that restarts the batch or misses the overrun would forward the wrong number of requests or leave the flag low. It also covers a select change in the middle of a batch and trigger selects that are out of range. A broken restart would emit the event early, and a faulty decode would open the gate from an input that does not exist.

// File: rtl/dmarr_pkg.sv
// Package: shared control word layout and types for the request router channel.
// Assumes a fixed 32-bit control word whose field positions are software visible.
package dmarr_pkg;
    localparam int CTRL_W    = 32;
    localparam int RSEL_W    = 8;
    localparam int CNT_W     = 5;
    localparam int SSEL_W    = 5;
    localparam logic [31:0] CTRL_MASK = 32'h1FFF_03FF;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic [SSEL_W-1:0] sync_sel;
        logic [CNT_W-1:0]  count;
        edge_mode_e        edge_mode;
        logic              sync_en;
        logic              evt_en;
        logic              ovr_ie;
        logic [RSEL_W-1:0] req_sel;
    } cfg_t;
endpackage

// File: rtl/dmarr_sel.sv
// Module: code-indexed one-bit selector. Code BASE+i picks vec[i]; any other code gives 0.
// Assumes BASE+N fits in the code width.
module dmarr_sel #(
    parameter int N      = 16,
    parameter int CODE_W = 5,
    parameter int BASE   = 0
) (
    input  logic [N-1:0]      vec,
    input  logic [CODE_W-1:0] code,
    output logic              out
);
    // Purpose: scan all legal codes and pick the matching line.
    always_comb begin
        out = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (code == CODE_W'(i + BASE)) out = vec[i];
        end
    end
endmodule

// File: rtl/dmarr_cfg.sv
// Module: control and status write decode. Holds the control word, applies the count
// write lock, flags select changes and decodes the overrun clear.
// Assumes writes are single-cycle strobes; address 0 is control, address 1 is status.
module dmarr_cfg
    import dmarr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output cfg_t        cfg,
    output logic        sel_change,
    output logic        ovr_clr
);
    logic ctrl_wr;

    assign ctrl_wr    = wr_en && !wr_addr;
    assign ovr_clr    = wr_en && wr_addr && wr_data[0];
    assign sel_change = ctrl_wr &&
                        ((wr_data[7:0] != cfg.req_sel) || (wr_data[28:24] != cfg.sync_sel));

    // Purpose: update the control fields; the count moves only while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.req_sel   <= wr_data[7:0];
            cfg.ovr_ie    <= wr_data[8];
            cfg.evt_en    <= wr_data[9];
            cfg.sync_en   <= wr_data[16];
            cfg.edge_mode <= edge_mode_e'(wr_data[18:17]);
            cfg.sync_sel  <= wr_data[28:24];
            if (!cfg.sync_en && !cfg.evt_en) cfg.count <= wr_data[23:19];
        end
    end
endmodule

// File: rtl/dmarr_gate.sv
// Module: forwarding gate. Detects request and trigger edges, counts forwarded
// requests per batch, opens and closes the gate, pulses the batch event and
// keeps the sticky overrun flag.
// Assumes routed inputs are already synchronous to clk.
module dmarr_gate
    import dmarr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_mux,
    input  logic             sync_mux,
    input  logic             sync_en,
    input  logic             evt_en,
    input  edge_mode_e       edge_mode,
    input  logic [CNT_W-1:0] count,
    input  logic             restart,
    input  logic             ovr_clr,
    output logic             req_out,
    output logic             evt_out,
    output logic             ovr_flag
);
    logic             req_q, sync_q, hold, active;
    logic [CNT_W-1:0] cnt;
    logic             rise, hit, open_gate, fwd, done;

    // Purpose: classify the routed trigger against its registered copy.
    always_comb begin
        unique case (edge_mode)
            EDGE_RISE: hit = sync_mux && !sync_q;
            EDGE_FALL: hit = !sync_mux && sync_q;
            EDGE_BOTH: hit = sync_mux ^ sync_q;
            default:   hit = 1'b0;
        endcase
    end

    assign rise      = req_mux && !req_q;
    assign open_gate = !sync_en || active;
    assign fwd       = rise && open_gate;
    assign done      = fwd && (cnt == count);
    assign req_out   = req_mux && (hold || fwd);

    // Purpose: register input copies and hold a forwarded request until it falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            sync_q <= 1'b0;
            hold   <= 1'b0;
        end else begin
            req_q  <= req_mux;
            sync_q <= sync_mux;
            hold   <= req_mux && (hold || fwd);
        end
    end

    // Purpose: count forwarded requests within a batch.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (fwd)     cnt <= done ? '0 : cnt + 1'b1;
    end

    // Purpose: open the gate on a trigger edge and close it when a batch completes.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (!sync_en) active <= 1'b0;
        else if (hit)     active <= 1'b1;
        else if (done)    active <= 1'b0;
    end

    // Purpose: one-cycle batch event and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_out  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            evt_out <= evt_en && done;
            if (sync_en && hit && active && !done) ovr_flag <= 1'b1;
            else if (ovr_clr)                      ovr_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_req_router.sv
// Module: top of one request router channel. Routes a chosen peripheral request
// through a trigger-gated, batch-counting forwarding gate.
// Assumes N_REQ fits the 8-bit request code and N_SYNC fits the 5-bit trigger code.
module dma_req_router
    import dmarr_pkg::*;
#(
    parameter int N_REQ  = 17,
    parameter int N_SYNC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req_in,
    input  logic [N_SYNC-1:0] sync_in,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_addr,
    output logic [31:0]       rd_data,
    output logic              req_out,
    output logic              evt_out,
    output logic              irq
);
    cfg_t cfg;
    logic sel_change, ovr_clr, req_mux, sync_mux, ovr_flag;

    dmarr_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg(cfg), .sel_change(sel_change), .ovr_clr(ovr_clr)
    );

    dmarr_sel #(.N(N_REQ), .CODE_W(RSEL_W), .BASE(1)) u_req_sel (
        .vec(req_in), .code(cfg.req_sel), .out(req_mux)
    );

    dmarr_sel #(.N(N_SYNC), .CODE_W(SSEL_W), .BASE(0)) u_sync_sel (
        .vec(sync_in), .code(cfg.sync_sel), .out(sync_mux)
    );

    dmarr_gate u_gate (
        .clk(clk), .rst_n(rst_n), .req_mux(req_mux), .sync_mux(sync_mux),
        .sync_en(cfg.sync_en), .evt_en(cfg.evt_en), .edge_mode(cfg.edge_mode),
        .count(cfg.count), .restart(sel_change), .ovr_clr(ovr_clr),
        .req_out(req_out), .evt_out(evt_out), .ovr_flag(ovr_flag)
    );

    assign irq = ovr_flag && cfg.ovr_ie;

    // Purpose: read mux for the control image and the status word.
    always_comb begin
        if (rd_addr) rd_data = {31'b0, ovr_flag};
        else         rd_data = {3'b0, cfg.sync_sel, cfg.count, cfg.edge_mode, cfg.sync_en,
                                6'b0, cfg.evt_en, cfg.ovr_ie, cfg.req_sel};
    end
endmodule

// File: rtl/dma_req_router_chk.sv
// Module: protocol checker for the router channel, bound to the top.
module dma_req_router_chk
    import dmarr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [31:0] wr_data,
    input cfg_t        cfg,
    input logic        req_out,
    input logic        evt_out,
    input logic        ovr_flag
);
    p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |=> !evt_out);

    p_no_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.req_sel == '0) |-> !req_out);

    p_count_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sync_en || cfg.evt_en) |=> $stable(cfg.count));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(wr_en && wr_addr && wr_data[0])) |=> ovr_flag);

    p_ovr_needs_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cfg.sync_en));
endmodule

bind dma_req_router dma_req_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .req_out(req_out), .evt_out(evt_out), .ovr_flag(ovr_flag)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] req_in = '0;
    logic [15:0] sync_in = '0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        req_out, evt_out, irq;

    int checks = 0;
    int errors = 0;

    // reference state derived from the requirements
    logic [31:0] m_cfg;
    logic        m_reqq, m_syncq, m_hold, m_active, m_evt, m_ovr;
    logic [4:0]  m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .sync_in(sync_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .req_out(req_out), .evt_out(evt_out), .irq(irq)
    );

    function automatic logic f_req_mux();
        int s = int'(m_cfg[7:0]);
        return (s >= 1 && s <= 17) ? req_in[s-1] : 1'b0;   // R2
    endfunction

    function automatic logic f_sync_mux();
        int s = int'(m_cfg[28:24]);
        return (s < 16) ? sync_in[s] : 1'b0;                // R11
    endfunction

    function automatic logic f_hit(input logic cur, input logic prev);
        case (m_cfg[18:17])                                 // R5
            2'd1:    return cur && !prev;
            2'd2:    return !cur && prev;
            2'd3:    return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg = '0; m_reqq = 0; m_syncq = 0; m_hold = 0; m_active = 0;
        m_evt = 0; m_ovr = 0; m_cnt = '0;
    endtask

    // One cycle: check outputs after inputs settle, then advance the model at the edge.
    task automatic tick(input string tag);
        logic rq, sy, rise, hit, se, ege, fwd, done, restart, wc;
        logic [31:0] nc;
        #1;
        rq   = f_req_mux();
        sy   = f_sync_mux();
        se   = m_cfg[16];
        ege  = m_cfg[9];
        rise = rq && !m_reqq;
        hit  = f_hit(sy, m_syncq);
        fwd  = rise && (!se || m_active);
        done = fwd && (m_cnt == m_cfg[23:19]);
        check(tag, "req_out", {31'b0, req_out}, {31'b0, rq && (m_hold || fwd)});
        check(tag, "evt_out", {31'b0, evt_out}, {31'b0, m_evt});
        check(tag, "irq", {31'b0, irq}, {31'b0, m_ovr && m_cfg[8]});
        check(tag, "rd_data", rd_data, rd_addr ? {31'b0, m_ovr} : m_cfg);
        wc = wr_en && !wr_addr;
        restart = wc && ((wr_data[7:0] != m_cfg[7:0]) || (wr_data[28:24] != m_cfg[28:24]));
        nc = m_cfg;
        if (wc) begin
            nc = wr_data & 32'h1FFF_03FF;
            if (se || ege) nc[23:19] = m_cfg[23:19];        // R7
        end
        @(posedge clk);
        m_hold = rq && (m_hold || fwd);
        if (restart) m_cnt = '0;                            // R10
        else if (fwd) m_cnt = done ? 5'd0 : m_cnt + 5'd1;
        if (!se) m_active = 0;
        else if (hit) m_active = 1;
        else if (done) m_active = 0;
        if (se && hit && m_active_prev(hit, done)) m_ovr = 1; // R8
        else if (wr_en && wr_addr && wr_data[0]) m_ovr = 0; // R9
        m_evt = ege && done;                                // R6
        m_reqq = rq; m_syncq = sy; m_cfg = nc;
        @(negedge clk);
    endtask

    // overrun condition uses the pre-edge batch state, saved before the update
    logic m_act_saved;
    function automatic logic m_active_prev(input logic hit, input logic done);
        return hit && m_act_saved && !done;
    endfunction

    task automatic step(input string tag);
        m_act_saved = m_active;
        tick(tag);
    endtask

    task automatic wr(input string tag, input logic a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 0; wr_data = '0;
    endtask

    function automatic logic [31:0] ctrl(input int rsel, input bit ie, input bit ege,
                                         input bit se, input int edge_m, input int cnt,
                                         input int ssel);
        return {3'b0, 5'(ssel), 5'(cnt), 2'(edge_m), se, 6'b0, ege, ie, 8'(rsel)};
    endfunction

    task automatic pulse(input string tag);
        req_in = '1; step(tag); step(tag);
        req_in = '0; step(tag); step(tag);
    endtask

    task automatic sync_toggle(input string tag, input int idx);
        sync_in[idx] = ~sync_in[idx]; step(tag); step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        m_act_saved = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on both addresses
        step("R1");
        rd_addr = 1; step("R1"); rd_addr = 0;

        // R2: routing decode including empty and reserved codes
        wr("R2", 0, ctrl(0, 0, 0, 0, 0, 0, 0));
        pulse("R2");
        wr("R2", 0, ctrl(18, 0, 0, 0, 0, 0, 0));
        pulse("R2");
        wr("R2", 0, ctrl(5, 0, 0, 0, 0, 0, 0));
        req_in = 17'h00010; step("R2"); step("R2");
        req_in = 17'h00020; step("R2"); step("R2");
        req_in = 17'h00000; step("R2");
        wr("R2", 0, ctrl(17, 0, 0, 0, 0, 0, 0));
        req_in = 17'h10000; step("R2"); req_in = '0; step("R2");

        // R3: plain pass-through
        wr("R3", 0, ctrl(3, 0, 0, 0, 0, 0, 0));
        repeat (3) pulse("R3");

        // R4 with R5 rising: blocked before trigger, then count+1 = 3 requests
        wr("R4", 0, ctrl(3, 0, 0, 0, 1, 2, 2));
        wr("R4", 0, ctrl(3, 0, 0, 1, 1, 2, 2));
        repeat (3) pulse("R4");
        sync_toggle("R5", 2);
        repeat (5) pulse("R4");
        sync_toggle("R5", 2);       // falling edge: no effect in rising mode
        repeat (2) pulse("R5");
        // R5 falling, both and none
        wr("R5", 0, ctrl(3, 0, 0, 0, 2, 2, 2));
        wr("R5", 0, ctrl(3, 0, 0, 1, 2, 2, 2));
        sync_toggle("R5", 2); sync_toggle("R5", 2);
        repeat (4) pulse("R5");
        wr("R5", 0, ctrl(3, 0, 0, 1, 3, 2, 2));
        sync_toggle("R5", 2);
        repeat (4) pulse("R5");
        wr("R5", 0, ctrl(3, 0, 0, 1, 0, 2, 2));
        sync_toggle("R5", 2); sync_toggle("R5", 2);
        repeat (2) pulse("R5");

        // R6: event pacing without sync, batch of 2
        wr("R6", 0, ctrl(3, 0, 0, 0, 1, 1, 0));
        wr("R6", 0, ctrl(3, 0, 1, 0, 1, 1, 0));
        repeat (5) pulse("R6");
        // R7: count write refused while event enable is set
        wr("R7", 0, ctrl(3, 0, 1, 0, 1, 9, 0));
        step("R7");
        wr("R7", 0, ctrl(3, 0, 0, 0, 1, 9, 0));
        wr("R7", 0, ctrl(3, 0, 0, 0, 1, 7, 0));
        step("R7");

        // R8: trigger edge inside an open batch of 4
        wr("R8", 0, ctrl(4, 1, 1, 0, 1, 3, 1));
        wr("R8", 0, ctrl(4, 1, 1, 1, 1, 3, 1));
        sync_in = '0; step("R8");
        sync_toggle("R8", 1);
        pulse("R8");
        sync_toggle("R8", 1); sync_toggle("R8", 1);
        repeat (4) pulse("R8");
        rd_addr = 1; step("R8");
        // R9: write-one clear; writing zero keeps the flag
        wr("R9", 1, 32'h0); step("R9");
        wr("R9", 1, 32'h1); step("R9");
        rd_addr = 0;

        // R10: changing the request select mid-batch restarts the count
        wr("R10", 0, ctrl(4, 0, 0, 0, 1, 2, 1));
        wr("R10", 0, ctrl(4, 0, 1, 0, 1, 2, 1));
        repeat (2) pulse("R10");
        wr("R10", 0, ctrl(6, 0, 1, 0, 1, 2, 1));
        repeat (4) pulse("R10");
        wr("R10", 0, ctrl(6, 0, 1, 0, 1, 2, 3));
        repeat (3) pulse("R10");

        // R11: out-of-range trigger select never opens the gate
        wr("R11", 0, ctrl(6, 0, 0, 0, 3, 0, 20));
        wr("R11", 0, ctrl(6, 0, 0, 1, 3, 0, 20));
        sync_in = '1; step("R11"); sync_in = '0; step("R11");
        repeat (2) pulse("R11");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            req_in = 17'($urandom);
            if ($urandom % 6 == 0) sync_in = 16'($urandom);
            rd_addr = ($urandom % 4 == 0);
            if ($urandom % 50 == 0) begin
                logic [31:0] d = $urandom & 32'h1FFF_03FF;
                d[7:0]   = 8'($urandom % 20);
                d[28:24] = 5'($urandom % 18);
                if ($urandom % 3 == 0) begin d[16] = 0; d[9] = 0; end
                wr("RND", 0, d);
            end else if ($urandom % 80 == 0) begin
                wr("RND", 1, 32'($urandom % 2));
            end else begin
                step("RND");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule